// File: doc/BRIEF.md
# ADC Conversion Control Register Block

This block is the digital front end of a multi-channel analog-to-digital converter. It holds a control/status register and a read-only result register behind a simple 32-bit register port. Software picks a channel, a reference source, a clock divider and an interrupt enable, then sets a start bit. After a conversion interval whose length follows the divider, the block stores a 10-bit ratiometric result, drops the start bit and can raise an interrupt.

Channel samples arrive as parallel 32-bit digital values, one per channel. The two references also arrive as parallel values: the internal one is a parameter and the external one is an input port. A small restoring divider forms the result while the conversion interval runs. Software clears the interrupt flag by writing a one to it. A reset bit inside the control register returns the whole block to its power-on state.

Top module: `adc_ctl_regs`

## Requirements
- R1: The control register is at byte offset 0x0 and the result register is at 0x4. The result register is read-only. Writes to it, or to any other or misaligned address, change nothing. Reads from any address other than 0x0 or 0x4 return 0.
- R2: Control fields are: channel [27:24], interrupt enable [21], reference select [19], interrupt flag [18], enable [17], soft reset [16], convert/busy [14] and divider [8:1]. Other bits read back as written.
- R3: After reset the control register reads 0x000C0001, the result register reads 0 and irq is low.
- R4: Writing 1 to bit 18 clears the interrupt flag and drops irq. Writing 0 to bit 18 leaves the flag as it was. irq is never high while the flag is clear.
- R5: A control write with bit 16 set restores the reset values of R3 and cancels any running conversion. The other bits of that write have no effect.
- R6: A conversion starts only on a control write that has enable set and moves the convert bit from 0 to 1. Rewriting convert as 1 does not restart the conversion. A write with enable set and convert 0 aborts a running conversion. With enable clear, a write neither starts nor aborts a conversion.
- R7: The new result is visible 40×(divider+1) clock cycles after the clock edge that takes the starting write.
- R8: The result is floor(sample×1024/reference), saturated at 1023. A reference of 0 gives 1023. Reference select 1 uses the internal value (default 2,000,000) and 0 uses ext_ref. The result is zero-extended to 32 bits.
- R9: On completion the result register updates and the convert bit clears. If interrupt enable is set, the flag sets and irq rises.
- R10: If the channel number is 8 or above (eight channels are implemented), completion changes neither the result nor irq, and the convert bit stays set.
- R11: The channel number, the channel sample and the reference are captured when the conversion starts. Later changes to them do not alter that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| chan_flat | input | 256 | Eight 32-bit channel samples, channel 0 in the low bits |
| ext_ref | input | 32 | External reference value |
| irq | output | 1 | Interrupt line |

## Verification
A wrong countdown or a stale divider state shows at the ports as a result that appears a cycle early or late. The bench catches this by reading the result register in the cycle before and the cycle of the expected update. A corrupted quotient or saturation path shows as a wrong value in that same cycle. A wrong flag or start-edge state shows within one conversion interval: irq fails to rise or fall, the convert bit does not clear, or a result appears after an abort or a soft reset.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  // control word field positions (decoded by software)
  localparam int F_CH_LO   = 24;
  localparam int F_CH_W    = 4;
  localparam int F_IE      = 21;
  localparam int F_REFSEL  = 19;
  localparam int F_FLAG    = 18;
  localparam int F_EN      = 17;
  localparam int F_SRST    = 16;
  localparam int F_CONV    = 14;
  localparam int F_DIV_LO  = 1;
  localparam int F_DIV_W   = 8;

  localparam int REG_W     = 32;
  localparam logic [REG_W-1:0] CON_RST_VAL = 32'h000C_0001;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CON,
    SEL_DATA
  } reg_sel_e;

endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH   = 8,
  parameter int SMP_W = 32,
  parameter int CH_W  = 4
) (
  input  logic [NCH*SMP_W-1:0] chan_flat,
  input  logic [CH_W-1:0]      ch,
  output logic [SMP_W-1:0]     sample,
  output logic                 ok
);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [SMP_W-1:0] lane [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = chan_flat[g*SMP_W +: SMP_W];
  end

  assign ok     = (32'(ch) < NCH);
  assign sample = ok ? lane[ch[SEL_W-1:0]] : '0;

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int PERIODS = 20,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [DIV_W-1:0] div,
  output logic             done
);
  localparam int CNT_W = $clog2(PERIODS * 2 * (1 << DIV_W) + 1);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(2 * PERIODS);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] div_ext, load_val;

  assign div_ext  = CNT_W'(div) + CNT_W'(1);
  assign load_val = STEP * div_ext - CNT_W'(1);
  assign done     = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (cancel) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_ratio_div.sv
module adc_ratio_div #(
  parameter int SMP_W    = 32,
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SMP_W-1:0]    num,
  input  logic [SMP_W-1:0]    den,
  output logic [RES_BITS-1:0] quo,
  output logic                ready
);
  localparam int CNT_W = $clog2(RES_BITS + 1);

  logic [SMP_W-1:0]    rem_q, rem_d;
  logic [RES_BITS-1:0] quo_q, quo_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SMP_W:0]      shifted, diff;
  logic                fits, saturate;

  assign shifted  = {rem_q, 1'b0};
  assign diff     = shifted - {1'b0, den};
  assign fits     = (shifted >= {1'b0, den});
  assign saturate = (den == '0) || (num >= den);
  assign quo      = quo_q;
  assign ready    = (cnt_q == '0);

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    cnt_d = cnt_q;
    if (start) begin
      if (saturate) begin
        quo_d = '1;
        cnt_d = '0;
      end else begin
        rem_d = num;
        quo_d = '0;
        cnt_d = CNT_W'(RES_BITS);
      end
    end else if (!ready) begin
      rem_d = fits ? diff[SMP_W-1:0] : shifted[SMP_W-1:0];
      quo_d = {quo_q[RES_BITS-2:0], fits};
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int SMP_W        = 32,
  parameter int ADDR_W       = 12,
  parameter int RES_BITS     = 10,
  parameter int CONV_PERIODS = 20,
  parameter int INT_REF      = 2000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [NCH*SMP_W-1:0] chan_flat,
  input  logic [SMP_W-1:0]     ext_ref,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] CON_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  // address decode
  reg_sel_e sel;
  always_comb begin
    if (bus_addr == CON_OFS)       sel = SEL_CON;
    else if (bus_addr == DATA_OFS) sel = SEL_DATA;
    else                           sel = SEL_NONE;
  end

  logic                wr_con;
  logic [REG_W-1:0]    con_q, con_d;
  logic [RES_BITS-1:0] res_q, res_d;
  logic                irq_q, irq_d;
  logic                chan_ok_q, chan_ok_d;
  logic                con_en, res_en;
  logic                start, cancel, fire;
  logic                tmr_done, div_ready;
  logic [SMP_W-1:0]    pick_sample, ref_val;
  logic                pick_ok;
  logic [RES_BITS-1:0] quo;

  assign wr_con = bus_wr && (sel == SEL_CON);

  adc_chan_pick #(
    .NCH   (NCH),
    .SMP_W (SMP_W),
    .CH_W  (F_CH_W)
  ) u_pick (
    .chan_flat (chan_flat),
    .ch        (bus_wdata[F_CH_LO +: F_CH_W]),
    .sample    (pick_sample),
    .ok        (pick_ok)
  );

  assign ref_val = bus_wdata[F_REFSEL] ? SMP_W'(INT_REF) : ext_ref;

  adc_conv_timer #(
    .PERIODS (CONV_PERIODS),
    .DIV_W   (F_DIV_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sn),
    .start  (start),
    .cancel (cancel),
    .div    (bus_wdata[F_DIV_LO +: F_DIV_W]),
    .done   (tmr_done)
  );

  adc_ratio_div #(
    .SMP_W    (SMP_W),
    .RES_BITS (RES_BITS)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_sn),
    .start (start),
    .num   (pick_sample),
    .den   (ref_val),
    .quo   (quo),
    .ready (div_ready)
  );

  // next state: bus write first, completion applied on top
  always_comb begin
    con_d     = con_q;
    res_d     = res_q;
    irq_d     = irq_q;
    chan_ok_d = chan_ok_q;
    start     = 1'b0;
    cancel    = 1'b0;
    if (wr_con) begin
      if (bus_wdata[F_SRST]) begin
        con_d  = CON_RST_VAL;
        res_d  = '0;
        irq_d  = 1'b0;
        cancel = 1'b1;
      end else begin
        con_d = bus_wdata;
        if (bus_wdata[F_FLAG]) begin
          con_d[F_FLAG] = 1'b0;
          irq_d         = 1'b0;
        end else begin
          con_d[F_FLAG] = con_q[F_FLAG];
        end
        if (bus_wdata[F_EN]) begin
          if (bus_wdata[F_CONV] && !con_q[F_CONV]) start  = 1'b1;
          else if (!bus_wdata[F_CONV])             cancel = 1'b1;
        end
      end
    end
    if (start) chan_ok_d = pick_ok;
    fire = tmr_done && !start && !cancel;
    if (fire && chan_ok_q) begin
      con_d[F_CONV] = 1'b0;
      res_d         = quo;
      if (con_d[F_IE]) begin
        con_d[F_FLAG] = 1'b1;
        irq_d         = 1'b1;
      end
    end
  end

  assign con_en = wr_con || fire;
  assign res_en = wr_con || fire;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      con_q     <= CON_RST_VAL;
      res_q     <= '0;
      irq_q     <= 1'b0;
      chan_ok_q <= 1'b0;
    end else begin
      if (con_en) con_q <= con_d;
      if (res_en) res_q <= res_d;
      irq_q     <= irq_d;
      chan_ok_q <= chan_ok_d;
    end
  end

  assign irq = irq_q;

  always_comb begin
    case (sel)
      SEL_CON:  bus_rdata = con_q;
      SEL_DATA: bus_rdata = {{(REG_W-RES_BITS){1'b0}}, res_q};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_ctl_regs_chk.sv
module adc_ctl_regs_chk
  import adc_ctl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_sn,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [REG_W-1:0]    bus_wdata,
  input logic                irq,
  input logic [REG_W-1:0]    con_q,
  input logic [RES_BITS-1:0] res_q,
  input logic                tmr_done,
  input logic                chan_ok_q,
  input logic                div_ready
);
  logic con_wr;
  assign con_wr = bus_wr && (bus_addr == '0);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> con_q[F_FLAG]); // R4

  AST_W1C_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_sn)
    con_wr && bus_wdata[F_FLAG] && !tmr_done |=> !irq); // R4

  AST_SOFT_RST_VALUE: assert property (@(posedge clk) disable iff (!rst_sn)
    con_wr && bus_wdata[F_SRST] |=> (con_q == CON_RST_VAL) && (res_q == '0) && !irq); // R5

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    !tmr_done && !(con_wr && bus_wdata[F_SRST]) |=> $stable(res_q)); // R1

  AST_DONE_CLEARS_CONV: assert property (@(posedge clk) disable iff (!rst_sn)
    tmr_done && chan_ok_q && !bus_wr |=> !con_q[F_CONV]); // R9

  AST_DIV_READY: assert property (@(posedge clk) disable iff (!rst_sn)
    tmr_done |-> div_ready); // R7

endmodule

bind adc_ctl_regs adc_ctl_regs_chk u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .con_q     (con_q),
  .res_q     (res_q),
  .tmr_done  (tmr_done),
  .chan_ok_q (chan_ok_q),
  .div_ready (div_ready)
);

// File: tb/adc_ctl_regs_bench.sv
module adc_ctl_regs_bench;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = 12'h004;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [255:0]  chan_flat;
  logic [31:0]   ext_ref = '0;
  logic          irq;
  logic [31:0]   smp [8];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int i = 0; i < 8; i++) chan_flat[i*32 +: 32] = smp[i];
  end

  adc_ctl_regs u_adc_ctl_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .chan_flat (chan_flat),
    .ext_ref   (ext_ref),
    .irq       (irq)
  );

  typedef struct {
    int          due;
    logic [31:0] exp_data;
    logic [31:0] old_data;
    logic        exp_irq;
    string       tag;
  } item_t;

  item_t sb [$];

  localparam logic [31:0] FLAG_B = 32'h1 << 18;
  localparam logic [31:0] CONV_B = 32'h1 << 14;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(int ch, bit ie, bit rs, bit fl, bit en, bit cv, int dv);
    return ((32'(ch) & 32'hF) << 24) | (32'(ie) << 21) | (32'(rs) << 19) |
           (32'(fl) << 18) | (32'(en) << 17) | (32'(cv) << 14) |
           ((32'(dv) & 32'hFF) << 1);
  endfunction

  function automatic logic [31:0] model(logic [31:0] s, logic [31:0] r);
    longint q;
    if (r == 0) return 32'd1023;
    q = (longint'(s) * 1024) / longint'(r);
    return (q > 1023) ? 32'd1023 : 32'(q);
  endfunction

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d, output int k);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 k = cyc;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 12'h004;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #2 v = bus_rdata;
  endtask

  // monitor: compares the result register around each expected completion
  always begin
    @(negedge clk);
    #2;
    if (sb.size() > 0) begin
      if (cyc == sb[0].due - 1)
        chk(bus_rdata == sb[0].old_data, {"R7 early ", sb[0].tag}, bus_rdata, sb[0].old_data);
      if (cyc == sb[0].due) begin
        chk(bus_rdata == sb[0].exp_data, {"R8 result ", sb[0].tag}, bus_rdata, sb[0].exp_data);
        chk(irq == sb[0].exp_irq, {"R9 irq ", sb[0].tag}, irq, sb[0].exp_irq);
        void'(sb.pop_front());
      end
    end
  end

  task automatic run_conv(input int ch, input bit ie, input bit rs, input int dv,
                          input logic [31:0] exp, input bit exp_irq, input string tag,
                          input bit poke);
    logic [31:0] old;
    int k;
    item_t it;
    bread(12'h004, old);
    bwrite(12'h000, cw(ch, ie, rs, 1, 1, 1, dv), k);
    it.due = k + 40 * (dv + 1);
    it.exp_data = exp; it.old_data = old; it.exp_irq = exp_irq; it.tag = tag;
    sb.push_back(it);
    if (poke) smp[ch[2:0]] = 32'd2000;   // R11 sample changed mid-conversion
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog act=hang exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    int k;
    for (int i = 0; i < 8; i++) smp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 reset state
    bread(12'h000, v); chk(v == 32'h000C0001, "R3 con", v, 32'h000C0001);
    bread(12'h004, v); chk(v == 0, "R3 data", v, 0);
    chk(irq == 1'b0, "R3 irq", irq, 0);

    // R1 misaligned, data and unmapped writes ignored
    bwrite(12'h001, 32'hFFFF_FFFF, k);
    bread(12'h000, v); chk(v == 32'h000C0001, "R1 misaligned write", v, 32'h000C0001);
    bwrite(12'h004, 32'h0000_03FF, k);
    bread(12'h004, v); chk(v == 0, "R1 data read-only", v, 0);
    bread(12'h008, v); chk(v == 0, "R1 unmapped read", v, 0);

    // main conversions
    smp[0] = 32'd500000;
    run_conv(0, 0, 1, 0, model(smp[0], 2000000), 0, "ch0 int", 0);
    w = cw(0, 0, 1, 1, 1, 1, 0) | 32'h0000_8001;
    bread(12'h000, v);
    chk(v == (cw(0, 0, 1, 1, 1, 1, 0) & ~CONV_B & ~FLAG_B), "R2 R9 con after done", v,
        cw(0, 0, 1, 1, 1, 1, 0) & ~CONV_B & ~FLAG_B);

    smp[3] = 32'd1500000;
    run_conv(3, 1, 1, 2, model(smp[3], 2000000), 1, "ch3 ie div2", 0);
    bread(12'h000, v);
    chk(v == (cw(3, 1, 1, 1, 1, 1, 2) & ~CONV_B), "R9 flag set conv clear", v,
        cw(3, 1, 1, 1, 1, 1, 2) & ~CONV_B);

    // R4 write-one-to-clear
    bwrite(12'h000, cw(3, 1, 1, 0, 1, 0, 2), k);
    bread(12'h000, v);
    chk(v == (cw(3, 1, 1, 0, 1, 0, 2) | FLAG_B), "R4 write 0 keeps flag", v, cw(3, 1, 1, 0, 1, 0, 2) | FLAG_B);
    chk(irq == 1'b1, "R4 irq kept", irq, 1);
    bwrite(12'h000, cw(3, 1, 1, 1, 1, 0, 2), k);
    bread(12'h000, v);
    chk(v == cw(3, 1, 1, 0, 1, 0, 2), "R4 write 1 clears flag", v, cw(3, 1, 1, 0, 1, 0, 2));
    chk(irq == 1'b0, "R4 irq dropped", irq, 0);

    // external reference, operand capture
    ext_ref = 32'd3000; smp[5] = 32'd1000;
    run_conv(5, 0, 0, 1, model(32'd1000, 32'd3000), 0, "R11 ext ref capture", 1);
    ext_ref = 32'd3000; smp[5] = 32'd3000;
    run_conv(5, 0, 0, 0, 32'd1023, 0, "R8 sample equals ref", 0);
    run_conv(0, 0, 1, 0, 32'd256, 0, "ch0 again", 0);
    smp[7] = 32'd1999999;
    run_conv(7, 0, 1, 0, model(smp[7], 2000000), 0, "R8 near full scale", 0);
    run_conv(3, 0, 1, 0, 32'd768, 0, "ch3 div0", 0);
    ext_ref = 32'd0; smp[5] = 32'd5;
    run_conv(5, 0, 0, 0, 32'd1023, 0, "R8 zero ref", 0);

    // R10 invalid channel
    run_conv(9, 1, 1, 0, 32'd1023, 0, "R10 invalid channel", 0);
    bread(12'h000, v);
    chk(v[14] == 1'b1, "R10 conv stays set", v[14], 1);
    bwrite(12'h000, cw(0, 0, 1, 1, 1, 0, 0), k);

    // R6 abort
    bwrite(12'h000, cw(0, 0, 1, 1, 1, 1, 0), k);
    repeat (10) @(negedge clk);
    bwrite(12'h000, cw(0, 0, 1, 1, 1, 0, 0), k);
    repeat (50) @(negedge clk);
    bread(12'h004, v); chk(v == 32'd1023, "R6 abort keeps result", v, 1023);

    // R6 enable clear: no start
    bwrite(12'h000, cw(0, 0, 1, 1, 0, 1, 0), k);
    repeat (50) @(negedge clk);
    bread(12'h004, v); chk(v == 32'd1023, "R6 no start without enable", v, 1023);
    bwrite(12'h000, cw(0, 0, 1, 1, 0, 0, 0), k);

    // R6 rewriting convert=1 does not restart
    begin
      item_t it;
      bread(12'h004, v);
      bwrite(12'h000, cw(0, 0, 1, 1, 1, 1, 0), k);
      it.due = k + 40; it.exp_data = 32'd256; it.old_data = v; it.exp_irq = 0;
      it.tag = "R6 no restart";
      sb.push_back(it);
      repeat (15) @(negedge clk);
      bwrite(12'h000, cw(0, 0, 1, 1, 1, 1, 0), k);
      wait (sb.size() == 0);
    end

    // R5 soft reset cancels
    bwrite(12'h000, cw(3, 1, 1, 1, 1, 1, 0), k);
    repeat (5) @(negedge clk);
    bwrite(12'h000, 32'h0F21_4000 | (32'h1 << 16), k);
    bread(12'h000, v); chk(v == 32'h000C0001, "R5 con restored", v, 32'h000C0001);
    bread(12'h004, v); chk(v == 0, "R5 data cleared", v, 0);
    repeat (60) @(negedge clk);
    bread(12'h004, v); chk(v == 0, "R5 cancelled conversion", v, 0);
    chk(irq == 1'b0, "R5 irq low", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule